// File: doc/BRIEF.md
# Local Interrupt Controller Base-Register Mode Sequencer

This block holds the 64-bit base register of one core's local interrupt controller. The register carries the memory-mapped base address, a bootstrap-core flag and two mode bits. Together the two mode bits select one of three operating modes: off, legacy memory-mapped, or extended register access.

Software updates the register through a write channel. Each write names a target mode. The block either applies the write or rejects it with a one-cycle access-error pulse. Transitions follow a strict ladder: off → legacy → extended, and any mode may drop back to off. Entering extended mode captures the core index as the controller ID and derives a clustered logical ID from it. Dropping to off reloads the ID and clears the logical ID.

The write channel is valid/ready. `wr_ready` is low during reset and during the first cycle after reset is released, and high from then on. A write is taken on a rising edge where both `wr_valid` and `wr_ready` are high. The block never stalls after that, so the producer can stream writes back to back. All outputs are registered and reflect a write from the edge that takes it.

Top module: `lapic_base_ctrl`

## Requirements
- R1: Synchronous reset (active-low `rst_n`) loads these values:
  - `base_reg` = 0xFEE00000, plus bit 8 if `core_idx` is 0, plus bit 11 if `max_mode` is not 0.
  - `apic_id` = `core_idx`, zero-extended.
  - `logical_id` = 0.
  - `acc_err` = 0.
- R2: `mode` is `base_reg[11:10]`, decoded as 00 off, 10 legacy, 11 extended. An accepted write requesting off (data bits 11:10 = 00) from another mode has these effects:
  - Bits 11 and 10 are cleared and the other bits are kept.
  - `apic_id` is reloaded from `core_idx`.
  - `logical_id` is cleared.
- R3: A write requesting legacy (10) is applied only from off: it sets bit 11. From extended, it raises `acc_err` and leaves every output unchanged.
- R4: A write requesting extended (11) is applied only from legacy, and only when `max_mode` = 2 (00 none, 01 legacy only, 10 extended allowed, 11 treated as legacy only). Otherwise it raises `acc_err` and leaves every output unchanged.
- R5: On entry to extended mode, `apic_id` is loaded with `core_idx`. It then holds its value through any write until the mode leaves extended.
- R6: On entry to extended mode, `logical_id` = ((id & 0xFFFF0) << 16) | (1 << (id & 0xF)), where id is the zero-extended `core_idx`, truncated to 32 bits.
- R7: A write with data bits 11:10 = 01 is invalid. It raises `acc_err` and changes nothing.
- R8: A write whose requested mode equals the current mode replaces every bit except 11:10 with the write data, without error.
- R9: A mode-changing write ignores all non-mode data bits. `acc_err` is high for exactly the cycle after each rejected write and low otherwise.
- R10: `wr_ready` is 0 in reset and during the first cycle after release, then 1. Writes are ignored when `wr_valid` and `wr_ready` are not both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_idx | input | IDX_W | Index of the owning core |
| max_mode | input | 2 | Highest mode permitted by configuration |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Block can take a write |
| wr_data | input | 64 | Write data (bits 11:10 select the requested mode) |
| mode | output | 2 | Current mode |
| base_reg | output | 64 | Current base register value |
| apic_id | output | 32 | Controller ID |
| logical_id | output | 32 | Logical destination ID |
| acc_err | output | 1 | One-cycle access-error pulse |

## Verification
The bench walks every (current mode, requested mode) pair, including the invalid code. This separates legal ladder steps from rejected ones, and separates same-mode field updates from mode changes. Mode-changing writes carry non-mode data so that a leak into the address field would show. Extended entry is tried under every `max_mode` value and with core indices whose low nibble and cluster bits both vary, which checks the logical-ID formula. Changing `core_idx` between captures shows exactly when the ID is sampled. Writes during the not-ready cycle after reset, and back-to-back rejected writes, show the acceptance rule and the pulse width of `acc_err`.

// File: rtl/lapic_base_pkg.sv
package lapic_base_pkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_BAD    = 2'b01,
    MODE_LEGACY = 2'b10,
    MODE_EXT    = 2'b11
  } lmode_e;

  typedef enum logic [1:0] {
    CAP_NONE   = 2'b00,
    CAP_LEGACY = 2'b01,
    CAP_EXT    = 2'b10,
    CAP_RSVD   = 2'b11
  } lcap_e;

  localparam int        EN_BIT   = 11;
  localparam int        EXT_BIT  = 10;
  localparam int        BSP_BIT  = 8;
  localparam logic [63:0] BASE_RST = 64'h0000_0000_FEE0_0000;

  // Decision taken for one accepted write
  typedef struct packed {
    logic       accept;
    logic       fault;
    logic       same;
    logic [1:0] next_mode;
    logic       load_id;
    logic       clr_lid;
    logic       set_lid;
  } mode_step_t;

endpackage

// File: rtl/lapic_mode_arbiter.sv
module lapic_mode_arbiter
  import lapic_base_pkg::*;
(
  input  lmode_e     cur_mode,
  input  lmode_e     req_mode,
  input  lcap_e      cap,
  output mode_step_t step
);

  logic legal;

  always_comb begin
    legal = 1'b0;
    unique case (req_mode)
      MODE_OFF:    legal = 1'b1;
      MODE_LEGACY: legal = (cur_mode == MODE_OFF) || (cur_mode == MODE_LEGACY);
      MODE_EXT:    legal = (cur_mode == MODE_EXT) ||
                           ((cur_mode == MODE_LEGACY) && (cap == CAP_EXT));
      default:     legal = 1'b0;
    endcase
  end

  always_comb begin
    step           = '0;
    step.accept    = legal;
    step.fault     = !legal;
    step.same      = legal && (req_mode == cur_mode);
    step.next_mode = req_mode;
    step.load_id   = legal && (req_mode != cur_mode) &&
                     ((req_mode == MODE_EXT) || (req_mode == MODE_OFF));
    step.clr_lid   = legal && (req_mode != cur_mode) && (req_mode == MODE_OFF);
    step.set_lid   = legal && (req_mode != cur_mode) && (req_mode == MODE_EXT);
  end

endmodule

// File: rtl/lapic_ldr_gen.sv
module lapic_ldr_gen #(
  parameter int IDX_W = 12
) (
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      ldr
);

  localparam int ONEHOT_W = 16;

  logic [31:0]         ext_id;
  logic [31:0]         cluster;
  logic [ONEHOT_W-1:0] member;

  assign ext_id  = 32'(idx);
  assign cluster = (ext_id & 32'h000F_FFF0) << 16;

  for (genvar g = 0; g < ONEHOT_W; g++) begin : g_member
    assign member[g] = (ext_id[3:0] == 4'(g));
  end

  assign ldr = cluster | {16'h0000, member};

endmodule

// File: rtl/lapic_base_ctrl.sv
module lapic_base_ctrl
  import lapic_base_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] core_idx,
  input  logic [1:0]       max_mode,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [63:0]      wr_data,
  output logic [1:0]       mode,
  output logic [63:0]      base_reg,
  output logic [31:0]      apic_id,
  output logic [31:0]      logical_id,
  output logic             acc_err
);

  localparam logic [63:0] MODE_MASK = (64'd1 << EN_BIT) | (64'd1 << EXT_BIT);

  logic [63:0] base_q;
  logic [31:0] id_q;
  logic [31:0] lid_q;
  logic        err_q;
  logic        rdy_q;
  logic [63:0] rst_base;
  logic [31:0] ldr_calc;
  logic        wr_fire;
  lmode_e      cur_mode;
  lmode_e      req_mode;
  mode_step_t  step;

  assign cur_mode = lmode_e'(base_q[EN_BIT:EXT_BIT]);
  assign req_mode = lmode_e'(wr_data[EN_BIT:EXT_BIT]);
  assign wr_fire  = wr_valid && rdy_q;

  always_comb begin
    rst_base = BASE_RST;
    if (core_idx == '0)
      rst_base[BSP_BIT] = 1'b1;
    if (lcap_e'(max_mode) != CAP_NONE)
      rst_base[EN_BIT] = 1'b1;
  end

  lapic_mode_arbiter u_arb (
    .cur_mode (cur_mode),
    .req_mode (req_mode),
    .cap      (lcap_e'(max_mode)),
    .step     (step)
  );

  lapic_ldr_gen #(.IDX_W(IDX_W)) u_ldr (
    .idx (core_idx),
    .ldr (ldr_calc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= rst_base;
      id_q   <= 32'(core_idx);
      lid_q  <= '0;
      err_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      err_q <= wr_fire && step.fault;
      if (wr_fire && step.accept) begin
        if (step.same)
          base_q <= (wr_data & ~MODE_MASK) | (base_q & MODE_MASK);
        else
          base_q <= (base_q & ~MODE_MASK) |
                    ({52'd0, step.next_mode, 10'd0} & MODE_MASK);
        if (step.load_id)
          id_q <= 32'(core_idx);
        if (step.clr_lid)
          lid_q <= '0;
        else if (step.set_lid)
          lid_q <= ldr_calc;
      end
    end
  end

  assign wr_ready   = rdy_q;
  assign mode       = base_q[EN_BIT:EXT_BIT];
  assign base_reg   = base_q;
  assign apic_id    = id_q;
  assign logical_id = lid_q;
  assign acc_err    = err_q;

endmodule

// File: rtl/lapic_base_ctrl_chk.sv
module lapic_base_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  max_mode,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [1:0]  wr_mode,
  input logic [1:0]  mode,
  input logic [63:0] base_reg,
  input logic [31:0] apic_id,
  input logic [31:0] logical_id,
  input logic        acc_err
);

  logic fire;
  assign fire = wr_valid && wr_ready;

  a_r7_bad_code_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_mode == 2'b01) |=> (acc_err && $stable(base_reg) && $stable(apic_id)));

  a_r3_legacy_only_from_off: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_mode == 2'b10 && mode == 2'b11) |=> (acc_err && $stable(base_reg)));

  a_r4_ext_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_mode == 2'b11 && mode != 2'b11 && (mode != 2'b10 || max_mode != 2'b10))
    |=> (acc_err && $stable(base_reg) && $stable(logical_id)));

  a_r2_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_mode == 2'b00 && mode != 2'b00) |=> (mode == 2'b00 && logical_id == 32'd0 && !acc_err));

  a_r6_ldr_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && wr_mode == 2'b11 && mode == 2'b10 && max_mode == 2'b10)
    |=> (mode == 2'b11 && logical_id[15:0] == (16'h0001 << apic_id[3:0]) &&
         logical_id[31:20] == apic_id[15:4] && logical_id[19:16] == 4'h0));

  a_r5_id_held_in_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> (mode != 2'b11 || $stable(apic_id)));

  a_r9_err_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> !acc_err);

endmodule

bind lapic_base_ctrl lapic_base_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .max_mode   (max_mode),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_mode    (wr_data[11:10]),
  .mode       (mode),
  .base_reg   (base_reg),
  .apic_id    (apic_id),
  .logical_id (logical_id),
  .acc_err    (acc_err)
);

// File: tb/test_lapic_base_ctrl.sv
`timescale 1ns/1ps
module test_lapic_base_ctrl;

  localparam int IDX_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [IDX_W-1:0] core_idx = 12'd5;
  logic [1:0]       max_mode = 2'd2;
  logic             wr_valid = 1'b0;
  logic             wr_ready;
  logic [63:0]      wr_data = 64'd0;
  logic [1:0]       mode;
  logic [63:0]      base_reg;
  logic [31:0]      apic_id;
  logic [31:0]      logical_id;
  logic             acc_err;

  int    vectors = 0;
  int    fails = 0;
  int    cycles = 0;
  bit    started = 0;
  string cur_req = "R1";

  logic [63:0] m_base;
  logic [31:0] m_id, m_lid;
  logic        m_err, m_rdy;
  logic [1:0]  m_cur, m_req;

  always #2.5 clk = ~clk;

  lapic_base_ctrl #(.IDX_W(IDX_W)) i_lapic_base_ctrl (
    .clk(clk), .rst_n(rst_n), .core_idx(core_idx), .max_mode(max_mode),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .mode(mode), .base_reg(base_reg), .apic_id(apic_id),
    .logical_id(logical_id), .acc_err(acc_err)
  );

  // Behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      m_base <= 64'hFEE0_0000 | ((core_idx == 0) ? 64'h100 : 64'h0) |
                ((max_mode != 0) ? 64'h800 : 64'h0);
      m_id   <= 32'(core_idx);
      m_lid  <= 32'd0;
      m_err  <= 1'b0;
      m_rdy  <= 1'b0;
    end else begin
      m_rdy <= 1'b1;
      m_err <= 1'b0;
      if (wr_valid && m_rdy) begin
        m_cur = m_base[11:10];
        m_req = wr_data[11:10];
        if (m_req == 2'b01) m_err <= 1'b1;
        else if (m_req == m_cur)
          m_base <= (wr_data & ~64'hC00) | (m_base & 64'hC00);
        else if (m_req == 2'b00) begin
          m_base <= m_base & ~64'hC00;
          m_id   <= 32'(core_idx);
          m_lid  <= 32'd0;
        end else if (m_req == 2'b10) begin
          if (m_cur == 2'b00) m_base <= m_base | 64'h800;
          else m_err <= 1'b1;
        end else begin
          if (m_cur == 2'b10 && max_mode == 2'd2) begin
            m_base <= m_base | 64'hC00;
            m_id   <= 32'(core_idx);
            m_lid  <= ((32'(core_idx) & 32'h000F_FFF0) << 16) |
                      (32'd1 << (32'(core_idx) & 32'hF));
          end else m_err <= 1'b1;
        end
      end
    end
  end

  task automatic cmp64(string what, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    cycles++;
    if (started) begin
      vectors++;
      cmp64("wr_ready",   64'(wr_ready),   64'(m_rdy));
      cmp64("mode",       64'(mode),       64'(m_base[11:10]));
      cmp64("base_reg",   base_reg,        m_base);
      cmp64("apic_id",    64'(apic_id),    64'(m_id));
      cmp64("logical_id", 64'(logical_id), 64'(m_lid));
      cmp64("acc_err",    64'(acc_err),    64'(m_err));
    end
  end

  task automatic wr(input logic [63:0] d, input string req);
    @(negedge clk);
    cur_req  = req;
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
    wr_data  = 64'h5A5A_0000_0000_0000;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [IDX_W-1:0] c, input logic [1:0] m);
    @(negedge clk);
    cur_req  = "R1";
    core_idx = c;
    max_mode = m;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    // R10: a write held during reset and the not-ready cycle is dropped
    wr_valid = 1'b1;
    wr_data  = 64'h0;
    repeat (3) @(negedge clk);
    cur_req = "R10";
    rst_n   = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    wr(64'h0000_0000_FEC0_08FF, "R8");   // same legacy mode: field update
    wr(64'h1234_5000_0000_0C00, "R9");   // enter extended, other data ignored (R6)
    wr(64'hABCD_0000_0000_0C55, "R5");   // same extended mode, ID held
    wr(64'h0000_0000_0000_0800, "R3");   // legacy from extended: error
    wr(64'h0000_0000_0000_0400, "R7");   // invalid code
    wr(64'h0000_0000_0000_0000, "R2");   // drop to off
    wr(64'h0000_0000_0000_0C00, "R4");   // extended from off: error
    wr(64'h0000_0000_0000_0800, "R3");   // legacy from off: ok
    max_mode = 2'd1;
    wr(64'h0000_0000_0000_0C00, "R4");   // not permitted by config
    max_mode = 2'd3;
    wr(64'h0000_0000_0000_0C00, "R4");   // reserved config
    max_mode = 2'd2;
    core_idx = 12'h2A5;
    wr(64'h0000_0000_0000_0C00, "R6");   // ID 0x2A5, LID 0x02A00020
    core_idx = 12'hFFF;
    wr(64'h0000_0000_0000_0C00, "R5");   // ID not recaptured
    wr(64'h0000_0000_0000_0000, "R2");   // ID reloads 0xFFF
    wr(64'h0000_0000_0000_0800, "R3");
    core_idx = 12'h01F;
    wr(64'h0000_0000_0000_0C00, "R6");
    // back-to-back rejected writes
    @(negedge clk);
    cur_req  = "R9";
    wr_valid = 1'b1;
    wr_data  = 64'h400;
    repeat (2) @(negedge clk);
    wr_data  = 64'h800;
    @(negedge clk);
    wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    // R10: idle data without valid
    cur_req = "R10";
    wr_data = 64'h0;
    repeat (3) @(negedge clk);
    do_reset(12'd0, 2'd0);                 // bsp set, enable clear
    wr(64'h0000_0000_0000_0800, "R3");
    wr(64'h0000_0000_0000_0C00, "R4");
    do_reset(12'd3, 2'd3);
    wr(64'h0000_0000_0000_0C00, "R4");
    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule